// File: doc/BRIEF.md
# Receive Header-Split Buffer Placer

This block moves one received Ethernet frame, waiting at the head of the receive FIFO, into the host buffers named by a receive descriptor. For each descriptor it accepts, it decides which buffer or buffers take which bytes. It issues the writes on a header write channel and a data write channel, waits for the DMA engine to report each write done, and then presents the fields to write back into the descriptor. A frame longer than one data buffer is spread over several descriptors. The block keeps a running byte offset between those descriptors and marks end-of-packet only on the last one.

Three buffer modes are chosen by a 3-bit buffer-type field: a legacy single buffer, an advanced single buffer, and header split. In header-split mode the header bytes, up to a split point supplied from outside, go to the header buffer. The payload goes to the data buffer. Both writes are launched together, and the descriptor retires only when both have completed. A frame that cannot be placed is dropped with an error pulse, so the receive path never hangs.

Command channels and the writeback port use valid/ready. Once valid is raised, valid and its fields stay unchanged until ready is seen high at a clock edge. A downstream stall only delays the placement and never alters it. The descriptor input uses valid/ready in the same way. The frame head is plain: `frm_valid` with its length and split point, and a one-cycle `frm_pop` request.

Top module: `rxp_hdr_split_placer`

## Requirements
- R1: The buffer-type input selects the mode: 3'b000 legacy single buffer, 3'b001 advanced single buffer, 3'b101 header split. Any other code makes every frame an error drop (R9).
- R2: With `cfg_lpe` high, the data buffer holds `cfg_data_sz`×1024 bytes and the header buffer holds `cfg_hdr_sz` bytes. With `cfg_lpe` low, the data buffer holds `cfg_ring_bytes` bytes and the header buffer holds zero bytes.
- R3: In both single-buffer modes, a nonzero frame that fits the data buffer is written whole to the data address with source offset 0 in one command. Writeback is header length 0, split flag 0, data length equal to the frame length, and end-of-packet set.
- R4: In header-split mode, a new frame no longer than the header buffer is written whole to the header address, and no data command is issued. Writeback is header length equal to the frame length, split flag 0 and data length 0.
- R5: In header-split mode, a larger new frame with a split point in the range 0 < split ≤ header buffer and split < length is handled as follows. The header command carries `split` bytes. The data command carries min(length−split, data buffer) bytes from source offset `split`. Both commands are raised in the same cycle. Writeback is header length = split, split flag 1, data length = bytes sent to the data buffer.
- R6: A continuation descriptor (running offset nonzero) writes only the data buffer. It carries min(length−offset, data buffer) bytes from source offset = offset. Writeback is header length 0 and split flag 0.
- R7: Writeback is not offered until every command issued for the descriptor has been reported done. The two done pulses may arrive in either order or in the same cycle.
- R8: The descriptor-done bit is set in every writeback. End-of-packet is set exactly when the bytes placed so far reach the frame length. `frm_pop` pulses at that writeback handshake, and the running offset returns to 0. Otherwise the offset advances by the bytes placed.
- R9: A frame that cannot be placed causes an `err` pulse together with `frm_pop` in the cycle it is presented with a descriptor. The descriptor is not taken, no command is issued, and the offset returns to 0. This covers: zero length, a single-buffer frame that does not fit, a split frame with no usable split point, a zero data buffer where data is needed, and an unknown type.
- R10: `desc_ready` is high only while idle with a placeable frame present. `busy` is high from the accepting edge until the writeback handshake.
- R11: A command or writeback held without ready keeps its valid high and its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buf_type | input | 3 | Buffer mode code |
| cfg_lpe | input | 1 | Large-packet enable; selects buffer size source |
| cfg_data_sz | input | 8 | Data buffer size in 1 KB units (used when cfg_lpe=1) |
| cfg_hdr_sz | input | 8 | Header buffer size in bytes (used when cfg_lpe=1) |
| cfg_ring_bytes | input | LEN_W | Data buffer size in bytes when cfg_lpe=0 |
| frm_valid | input | 1 | A frame is at the FIFO head |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_split | input | LEN_W | Header/payload split point, 0 if none |
| frm_pop | output | 1 | Remove the head frame from the FIFO |
| desc_valid | input | 1 | A descriptor is offered |
| desc_ready | output | 1 | Descriptor accepted at this edge when valid |
| desc_hdr_addr | input | ADDR_W | Header buffer address |
| desc_data_addr | input | ADDR_W | Data buffer address |
| hwr_valid | output | 1 | Header write command valid |
| hwr_ready | input | 1 | Header write command accepted |
| hwr_addr | output | ADDR_W | Header write address |
| hwr_len | output | LEN_W | Header write byte count (source offset is 0) |
| hwr_done | input | 1 | Header write completed |
| dwr_valid | output | 1 | Data write command valid |
| dwr_ready | input | 1 | Data write command accepted |
| dwr_addr | output | ADDR_W | Data write address |
| dwr_src_off | output | LEN_W | Offset of first byte within the frame |
| dwr_len | output | LEN_W | Data write byte count |
| dwr_done | input | 1 | Data write completed |
| wb_valid | output | 1 | Writeback fields valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_hdr_len | output | LEN_W | Header length field |
| wb_split | output | 1 | Split flag |
| wb_data_len | output | LEN_W | Data length field |
| wb_dd | output | 1 | Descriptor-done status |
| wb_eop | output | 1 | End-of-packet status |
| busy | output | 1 | A placement is in progress |
| err | output | 1 | Frame dropped as unplaceable |

## Verification
A corrupted running offset shows at the next continuation descriptor: the data command's source offset and length are wrong, and end-of-packet comes too early, too late, or never. So the fault is visible within one descriptor. A completion counter that miscounts shows as writeback rising before the second done pulse, or not rising at all. Both are caught in the cycle they happen, because the bench drives the done pulses in either order and in the same cycle. A wrong plan register shows on the command fields in the cycle after acceptance. A lost stall shows as valid dropping, checked on the first held cycle.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int SZ_W      = 8;
  localparam int DSZ_SHIFT = 10;
  localparam logic [2:0] TY_LEGACY = 3'b000;
  localparam logic [2:0] TY_ONEBUF = 3'b001;
  localparam logic [2:0] TY_SPLIT  = 3'b101;

  typedef enum logic [1:0] {M_LEGACY, M_ONEBUF, M_SPLIT, M_BAD} mode_e;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB} top_st_e;
  typedef enum logic [1:0] {C_IDLE, C_REQ, C_WAIT} chan_st_e;
endpackage

// File: rtl/rxp_cfg_decode.sv
module rxp_cfg_decode
  import rxp_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CW    = 19
) (
  input  logic [2:0]       buf_type,
  input  logic             lpe,
  input  logic [SZ_W-1:0]  data_sz,
  input  logic [SZ_W-1:0]  hdr_sz,
  input  logic [LEN_W-1:0] ring_bytes,
  output mode_e            mode,
  output logic [CW-1:0]    data_buf,
  output logic [CW-1:0]    hdr_buf
);
  always_comb begin
    case (buf_type)
      TY_LEGACY: mode = M_LEGACY;
      TY_ONEBUF: mode = M_ONEBUF;
      TY_SPLIT:  mode = M_SPLIT;
      default:   mode = M_BAD;
    endcase
  end

  always_comb begin
    if (lpe) begin
      data_buf = {{(CW-SZ_W-DSZ_SHIFT){1'b0}}, data_sz, {DSZ_SHIFT{1'b0}}};
      hdr_buf  = {{(CW-SZ_W){1'b0}}, hdr_sz};
    end else begin
      data_buf = {{(CW-LEN_W){1'b0}}, ring_bytes};
      hdr_buf  = '0;
    end
  end
endmodule

// File: rtl/rxp_place_plan.sv
module rxp_place_plan
  import rxp_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CW    = 19
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] split,
  input  logic [LEN_W-1:0] offset,
  input  mode_e            mode,
  input  logic [CW-1:0]    data_buf,
  input  logic [CW-1:0]    hdr_buf,
  output logic             bad,
  output logic             use_hdr,
  output logic             use_data,
  output logic [LEN_W-1:0] hdr_len,
  output logic [LEN_W-1:0] data_off,
  output logic [LEN_W-1:0] data_len,
  output logic [LEN_W-1:0] wbf_hdr_len,
  output logic             wbf_split,
  output logic [LEN_W-1:0] wbf_data_len,
  output logic [LEN_W-1:0] new_off,
  output logic             eop
);
  localparam int PAD = CW - LEN_W;

  logic [LEN_W-1:0] rem_cont, rem_first, cp_cont, cp_first;
  logic [CW-1:0]    len_x, split_x, rem_cont_x, rem_first_x;
  logic             dbuf_nz, split_ok;

  always_comb begin
    len_x       = {{PAD{1'b0}}, len};
    split_x     = {{PAD{1'b0}}, split};
    rem_cont    = len - offset;
    rem_first   = len - split;
    rem_cont_x  = {{PAD{1'b0}}, rem_cont};
    rem_first_x = {{PAD{1'b0}}, rem_first};
    cp_cont     = (rem_cont_x  <= data_buf) ? rem_cont  : data_buf[LEN_W-1:0];
    cp_first    = (rem_first_x <= data_buf) ? rem_first : data_buf[LEN_W-1:0];
    dbuf_nz     = (data_buf != '0);
    split_ok    = (split != '0) && (split_x <= hdr_buf) && (split < len) && dbuf_nz;
  end

  always_comb begin
    bad          = 1'b1;
    use_hdr      = 1'b0;
    use_data     = 1'b0;
    hdr_len      = '0;
    data_off     = '0;
    data_len     = '0;
    wbf_hdr_len  = '0;
    wbf_split    = 1'b0;
    wbf_data_len = '0;
    new_off      = '0;
    if (len != '0) begin
      case (mode)
        M_LEGACY, M_ONEBUF: begin
          if (offset == '0 && len_x <= data_buf) begin
            bad          = 1'b0;
            use_data     = 1'b1;
            data_len     = len;
            wbf_data_len = len;
            new_off      = len;
          end
        end
        M_SPLIT: begin
          if (offset >= len) begin
            bad = 1'b1;
          end else if (offset != '0) begin
            if (dbuf_nz) begin
              bad          = 1'b0;
              use_data     = 1'b1;
              data_off     = offset;
              data_len     = cp_cont;
              wbf_data_len = cp_cont;
              new_off      = offset + cp_cont;
            end
          end else if (len_x <= hdr_buf) begin
            bad         = 1'b0;
            use_hdr     = 1'b1;
            hdr_len     = len;
            wbf_hdr_len = len;
            new_off     = len;
          end else if (split_ok) begin
            bad          = 1'b0;
            use_hdr      = 1'b1;
            use_data     = 1'b1;
            hdr_len      = split;
            data_off     = split;
            data_len     = cp_first;
            wbf_hdr_len  = split;
            wbf_split    = 1'b1;
            wbf_data_len = cp_first;
            new_off      = split + cp_first;
          end
        end
        default: bad = 1'b1;
      endcase
    end
  end

  assign eop = (new_off == len);
endmodule

// File: rtl/rxp_wr_chan.sv
module rxp_wr_chan
  import rxp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmd_ready,
  input  logic done,
  output logic cmd_valid,
  output logic retire
);
  chan_st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= C_IDLE;
    end else begin
      case (st)
        C_IDLE:  if (start)     st <= C_REQ;
        C_REQ:   if (cmd_ready) st <= C_WAIT;
        C_WAIT:  if (done)      st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == C_REQ);
  assign retire    = (st == C_WAIT) && done;
endmodule

// File: rtl/rxp_hdr_split_placer.sv
module rxp_hdr_split_placer
  import rxp_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_buf_type,
  input  logic              cfg_lpe,
  input  logic [7:0]        cfg_data_sz,
  input  logic [7:0]        cfg_hdr_sz,
  input  logic [LEN_W-1:0]  cfg_ring_bytes,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [LEN_W-1:0]  frm_split,
  output logic              frm_pop,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_hdr_addr,
  input  logic [ADDR_W-1:0] desc_data_addr,
  output logic              hwr_valid,
  input  logic              hwr_ready,
  output logic [ADDR_W-1:0] hwr_addr,
  output logic [LEN_W-1:0]  hwr_len,
  input  logic              hwr_done,
  output logic              dwr_valid,
  input  logic              dwr_ready,
  output logic [ADDR_W-1:0] dwr_addr,
  output logic [LEN_W-1:0]  dwr_src_off,
  output logic [LEN_W-1:0]  dwr_len,
  input  logic              dwr_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [LEN_W-1:0]  wb_hdr_len,
  output logic              wb_split,
  output logic [LEN_W-1:0]  wb_data_len,
  output logic              wb_dd,
  output logic              wb_eop,
  output logic              busy,
  output logic              err
);
  localparam int CW     = ((LEN_W > SZ_W + DSZ_SHIFT) ? LEN_W : SZ_W + DSZ_SHIFT) + 1;
  localparam int N_CHAN = 2;
  localparam int CH_HDR = 0;
  localparam int CH_DAT = 1;

  mode_e          mode;
  logic [CW-1:0]  data_buf, hdr_buf;

  rxp_cfg_decode #(.LEN_W(LEN_W), .CW(CW)) u_cfg (
    .buf_type   (cfg_buf_type),
    .lpe        (cfg_lpe),
    .data_sz    (cfg_data_sz),
    .hdr_sz     (cfg_hdr_sz),
    .ring_bytes (cfg_ring_bytes),
    .mode       (mode),
    .data_buf   (data_buf),
    .hdr_buf    (hdr_buf)
  );

  logic [LEN_W-1:0] run_off;
  logic             c_bad, c_use_hdr, c_use_data, c_split, c_eop;
  logic [LEN_W-1:0] c_hdr_len, c_data_off, c_data_len;
  logic [LEN_W-1:0] c_wb_hlen, c_wb_dlen, c_new_off;

  rxp_place_plan #(.LEN_W(LEN_W), .CW(CW)) u_plan (
    .len          (frm_len),
    .split        (frm_split),
    .offset       (run_off),
    .mode         (mode),
    .data_buf     (data_buf),
    .hdr_buf      (hdr_buf),
    .bad          (c_bad),
    .use_hdr      (c_use_hdr),
    .use_data     (c_use_data),
    .hdr_len      (c_hdr_len),
    .data_off     (c_data_off),
    .data_len     (c_data_len),
    .wbf_hdr_len  (c_wb_hlen),
    .wbf_split    (c_split),
    .wbf_data_len (c_wb_dlen),
    .new_off      (c_new_off),
    .eop          (c_eop)
  );

  top_st_e st;
  logic    idle, accept, drop, wb_fire;

  assign idle       = (st == S_IDLE);
  assign desc_ready = idle && frm_valid && !c_bad;
  assign accept     = desc_ready && desc_valid;
  assign drop       = idle && frm_valid && desc_valid && c_bad;

  // Per-channel command/completion tracking
  logic [N_CHAN-1:0] ch_start, ch_ready, ch_done, ch_valid, ch_retire;

  assign ch_start[CH_HDR] = accept && c_use_hdr;
  assign ch_start[CH_DAT] = accept && c_use_data;
  assign ch_ready[CH_HDR] = hwr_ready;
  assign ch_ready[CH_DAT] = dwr_ready;
  assign ch_done[CH_HDR]  = hwr_done;
  assign ch_done[CH_DAT]  = dwr_done;

  generate
    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
      rxp_wr_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ch_start[g]),
        .cmd_ready (ch_ready[g]),
        .done      (ch_done[g]),
        .cmd_valid (ch_valid[g]),
        .retire    (ch_retire[g])
      );
    end
  endgenerate

  // Latched placement for the accepted descriptor
  logic [ADDR_W-1:0] p_hdr_addr, p_data_addr;
  logic [LEN_W-1:0]  p_hdr_len, p_data_off, p_data_len;
  logic [LEN_W-1:0]  p_wb_hlen, p_wb_dlen, p_new_off;
  logic              p_split, p_eop;
  logic [1:0]        need, cnt, cnt_next;

  assign cnt_next = cnt + {1'b0, ch_retire[CH_HDR]} + {1'b0, ch_retire[CH_DAT]};
  assign wb_fire  = (st == S_WB) && wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      run_off     <= '0;
      cnt         <= '0;
      need        <= '0;
      p_hdr_addr  <= '0;
      p_data_addr <= '0;
      p_hdr_len   <= '0;
      p_data_off  <= '0;
      p_data_len  <= '0;
      p_wb_hlen   <= '0;
      p_wb_dlen   <= '0;
      p_new_off   <= '0;
      p_split     <= 1'b0;
      p_eop       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (drop) begin
            run_off <= '0;
          end else if (accept) begin
            st          <= S_RUN;
            cnt         <= '0;
            need        <= {1'b0, c_use_hdr} + {1'b0, c_use_data};
            p_hdr_addr  <= desc_hdr_addr;
            p_data_addr <= desc_data_addr;
            p_hdr_len   <= c_hdr_len;
            p_data_off  <= c_data_off;
            p_data_len  <= c_data_len;
            p_wb_hlen   <= c_wb_hlen;
            p_wb_dlen   <= c_wb_dlen;
            p_new_off   <= c_new_off;
            p_split     <= c_split;
            p_eop       <= c_eop;
          end
        end
        S_RUN: begin
          if (cnt_next == need) begin
            st  <= S_WB;
            cnt <= '0;
          end else begin
            cnt <= cnt_next;
          end
        end
        S_WB: begin
          if (wb_ready) begin
            st      <= S_IDLE;
            run_off <= p_eop ? '0 : p_new_off;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hwr_valid   = ch_valid[CH_HDR];
  assign hwr_addr    = p_hdr_addr;
  assign hwr_len     = p_hdr_len;
  assign dwr_valid   = ch_valid[CH_DAT];
  assign dwr_addr    = p_data_addr;
  assign dwr_src_off = p_data_off;
  assign dwr_len     = p_data_len;

  assign wb_valid    = (st == S_WB);
  assign wb_hdr_len  = p_wb_hlen;
  assign wb_split    = p_split;
  assign wb_data_len = p_wb_dlen;
  assign wb_dd       = 1'b1;
  assign wb_eop      = p_eop;

  assign busy    = !idle;
  assign err     = drop;
  assign frm_pop = drop || (wb_fire && p_eop);
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_pop,
  input logic              desc_ready,
  input logic              hwr_valid,
  input logic              hwr_ready,
  input logic [ADDR_W-1:0] hwr_addr,
  input logic [LEN_W-1:0]  hwr_len,
  input logic              dwr_valid,
  input logic              dwr_ready,
  input logic [ADDR_W-1:0] dwr_addr,
  input logic [LEN_W-1:0]  dwr_src_off,
  input logic [LEN_W-1:0]  dwr_len,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [LEN_W-1:0]  wb_hdr_len,
  input logic              wb_split,
  input logic [LEN_W-1:0]  wb_data_len,
  input logic              wb_dd,
  input logic              wb_eop,
  input logic              busy,
  input logic              err
);
  // R11: held header command keeps valid and fields
  a_r11_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hwr_valid && !hwr_ready |=> hwr_valid && $stable(hwr_addr) && $stable(hwr_len));

  // R11: held data command keeps valid and fields
  a_r11_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_valid && !dwr_ready |=> dwr_valid && $stable(dwr_addr) && $stable(dwr_src_off)
                                && $stable(dwr_len));

  // R11: held writeback keeps valid and fields
  a_r11_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_hdr_len) && $stable(wb_split)
                              && $stable(wb_data_len) && $stable(wb_eop));

  // R8: descriptor-done always set in a writeback
  a_r8_dd_set: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_dd);

  // R8: a pop not caused by an error is an end-of-packet writeback handshake
  a_r8_pop_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
    frm_pop && !err |-> wb_valid && wb_ready && wb_eop);

  // R9: an error drop pops the frame and takes no descriptor
  a_r9_drop_pops: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> frm_pop && !desc_ready && !busy);

  // R10: no descriptor is taken while a placement is in progress
  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !desc_ready);

  // R7: writeback only after all commands have left
  a_r7_wb_after_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !hwr_valid && !dwr_valid);

  // R5: a split writeback reports a nonzero header length
  a_r5_split_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_split |-> wb_hdr_len != '0);
endmodule

bind rxp_hdr_split_placer rxp_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_rxp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_pop     (frm_pop),
  .desc_ready  (desc_ready),
  .hwr_valid   (hwr_valid),
  .hwr_ready   (hwr_ready),
  .hwr_addr    (hwr_addr),
  .hwr_len     (hwr_len),
  .dwr_valid   (dwr_valid),
  .dwr_ready   (dwr_ready),
  .dwr_addr    (dwr_addr),
  .dwr_src_off (dwr_src_off),
  .dwr_len     (dwr_len),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_hdr_len  (wb_hdr_len),
  .wb_split    (wb_split),
  .wb_data_len (wb_data_len),
  .wb_dd       (wb_dd),
  .wb_eop      (wb_eop),
  .busy        (busy),
  .err         (err)
);

// File: tb/tb_rxp_hdr_split_placer.sv
`timescale 1ns/1ps
module tb_rxp_hdr_split_placer;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]        cfg_buf_type = 3'b000;
  logic              cfg_lpe = 1'b0;
  logic [7:0]        cfg_data_sz = 8'd0, cfg_hdr_sz = 8'd0;
  logic [LEN_W-1:0]  cfg_ring_bytes = '0;
  logic              frm_valid = 1'b0;
  logic [LEN_W-1:0]  frm_len = '0, frm_split = '0;
  logic              frm_pop, desc_ready;
  logic              desc_valid = 1'b0;
  logic [ADDR_W-1:0] desc_hdr_addr = '0, desc_data_addr = '0;
  logic              hwr_valid, dwr_valid, wb_valid, wb_split, wb_dd, wb_eop, busy, err;
  logic              hwr_ready = 1'b0, dwr_ready = 1'b0, hwr_done = 1'b0, dwr_done = 1'b0;
  logic              wb_ready = 1'b0;
  logic [ADDR_W-1:0] hwr_addr, dwr_addr;
  logic [LEN_W-1:0]  hwr_len, dwr_src_off, dwr_len, wb_hdr_len, wb_data_len;

  rxp_hdr_split_placer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut (.*);

  int checks = 0;
  int failures = 0;
  int model_off = 0;

  // Expected plan, computed from the requirements
  bit e_bad, e_hdr, e_dat, e_split, e_eop;
  int e_hlen, e_doff, e_dlen, e_wbh, e_wbd, e_new;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_plan();
    int dbuf, hbuf, len, sp;
    dbuf = cfg_lpe ? int'(cfg_data_sz) * 1024 : int'(cfg_ring_bytes);   // R2
    hbuf = cfg_lpe ? int'(cfg_hdr_sz) : 0;
    len = int'(frm_len); sp = int'(frm_split);
    e_bad = 1; e_hdr = 0; e_dat = 0; e_split = 0;
    e_hlen = 0; e_doff = 0; e_dlen = 0; e_wbh = 0; e_wbd = 0; e_new = 0;
    if (len != 0) begin
      if (cfg_buf_type == 3'b000 || cfg_buf_type == 3'b001) begin    // R1 R3
        if (model_off == 0 && len <= dbuf) begin
          e_bad = 0; e_dat = 1; e_dlen = len; e_wbd = len; e_new = len;
        end
      end else if (cfg_buf_type == 3'b101) begin
        if (model_off >= len) e_bad = 1;
        else if (model_off != 0) begin                                // R6
          if (dbuf != 0) begin
            e_bad = 0; e_dat = 1; e_doff = model_off;
            e_dlen = imin(len - model_off, dbuf); e_wbd = e_dlen; e_new = model_off + e_dlen;
          end
        end else if (len <= hbuf) begin                               // R4
          e_bad = 0; e_hdr = 1; e_hlen = len; e_wbh = len; e_new = len;
        end else if (sp != 0 && sp <= hbuf && sp < len && dbuf != 0) begin   // R5
          e_bad = 0; e_hdr = 1; e_dat = 1; e_hlen = sp; e_doff = sp;
          e_dlen = imin(len - sp, dbuf); e_wbh = sp; e_split = 1; e_wbd = e_dlen;
          e_new = sp + e_dlen;
        end
      end
    end
    e_eop = (e_new == len);
  endtask

  // One descriptor placement, compared cycle by cycle
  task automatic place(input string tag, input int hd, input int dd,
                       input bit cmd_stall, input bit wb_stall);
    int last;
    model_plan();
    @(negedge clk);
    frm_valid = 1; desc_valid = 1;
    desc_hdr_addr = 32'h1000_0000 + checks; desc_data_addr = 32'h2000_0000 + checks;
    #1;
    eq("R10", {tag, " desc_ready"}, desc_ready, !e_bad);
    eq("R9",  {tag, " err"}, err, e_bad);
    eq("R9",  {tag, " pop on drop"}, frm_pop, e_bad);
    if (e_bad) begin
      @(negedge clk); desc_valid = 0; #1;
      eq("R9", {tag, " no busy after drop"}, busy, 0);
      eq("R9", {tag, " no hdr cmd"}, hwr_valid, 0);
      eq("R9", {tag, " no data cmd"}, dwr_valid, 0);
      model_off = 0;
      return;
    end
    @(negedge clk); desc_valid = 0;
    hwr_ready = !cmd_stall; dwr_ready = !cmd_stall; #1;
    eq("R10", {tag, " busy"}, busy, 1);
    eq("R5",  {tag, " hdr cmd valid"}, hwr_valid, e_hdr);
    eq("R5",  {tag, " data cmd valid"}, dwr_valid, e_dat);
    if (e_hdr) begin
      eq("R4", {tag, " hdr len"}, hwr_len, e_hlen);
      eq("R4", {tag, " hdr addr"}, hwr_addr, desc_hdr_addr);
    end
    if (e_dat) begin
      eq("R6", {tag, " data off"}, dwr_src_off, e_doff);
      eq("R6", {tag, " data len"}, dwr_len, e_dlen);
      eq("R3", {tag, " data addr"}, dwr_addr, desc_data_addr);
    end
    if (cmd_stall) begin
      @(negedge clk); hwr_ready = 1; dwr_ready = 1; #1;
      eq("R11", {tag, " hdr valid held"}, hwr_valid, e_hdr);
      eq("R11", {tag, " data valid held"}, dwr_valid, e_dat);
      if (e_dat) eq("R11", {tag, " data len held"}, dwr_len, e_dlen);
    end
    @(negedge clk); hwr_ready = 0; dwr_ready = 0;
    last = e_hdr && e_dat ? (hd > dd ? hd : dd) : (e_hdr ? hd : dd);
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      hwr_done = e_hdr && (k == hd);
      dwr_done = e_dat && (k == dd);
      #1;
      eq("R7", {tag, " no early writeback"}, wb_valid, 0);
    end
    @(negedge clk); hwr_done = 0; dwr_done = 0; wb_ready = !wb_stall; #1;
    eq("R7",  {tag, " writeback offered"}, wb_valid, 1);
    eq("R5",  {tag, " wb hdr len"}, wb_hdr_len, e_wbh);
    eq("R5",  {tag, " wb split"}, wb_split, e_split);
    eq("R6",  {tag, " wb data len"}, wb_data_len, e_wbd);
    eq("R8",  {tag, " wb dd"}, wb_dd, 1);
    eq("R8",  {tag, " wb eop"}, wb_eop, e_eop);
    eq("R8",  {tag, " pop"}, frm_pop, e_eop && !wb_stall);
    if (wb_stall) begin
      @(negedge clk); wb_ready = 1; #1;
      eq("R11", {tag, " wb held"}, wb_valid, 1);
      eq("R11", {tag, " wb len held"}, wb_data_len, e_wbd);
      eq("R8",  {tag, " pop after stall"}, frm_pop, e_eop);
    end
    @(negedge clk); wb_ready = 0; #1;
    eq("R10", {tag, " idle after wb"}, busy, 0);
    model_off = e_eop ? 0 : e_new;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    eq("R10", "reset busy", busy, 0);
    eq("R10", "reset desc_ready", desc_ready, 0);
    eq("R7",  "reset wb_valid", wb_valid, 0);
    eq("R5",  "reset cmd valids", {hwr_valid, dwr_valid}, 0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R3: legacy, ring size
    cfg_buf_type = 3'b000; cfg_lpe = 0; cfg_ring_bytes = 2048;
    frm_len = 1500; frm_split = 0;
    place("legacy", 0, 1, 0, 0);
    // R3: advanced single buffer, 1 KB units, with back-pressure
    cfg_buf_type = 3'b001; cfg_lpe = 1; cfg_data_sz = 2; cfg_hdr_sz = 128;
    frm_len = 2000;
    place("onebuf", 0, 2, 1, 1);
    // R3 R9: does not fit
    frm_len = 3000;
    place("onebuf_big", 0, 0, 0, 0);
    // R4: small frame into header buffer
    cfg_buf_type = 3'b101; frm_len = 100; frm_split = 40;
    place("hdr_only", 1, 0, 0, 0);
    // R5 R7: split, header done later than data
    frm_len = 1000; frm_split = 54;
    place("split_hd_late", 3, 0, 0, 0);
    // R7: data done later than header
    place("split_dd_late", 0, 2, 1, 0);
    // R5 R6 R8: jumbo frame over three descriptors
    frm_len = 5000; frm_split = 66;
    place("jumbo_first", 1, 1, 0, 1);
    place("jumbo_cont1", 0, 0, 0, 0);
    place("jumbo_last", 0, 1, 0, 1);
    // R9: no split point, split beyond header buffer
    frm_len = 1000; frm_split = 0;
    place("no_split", 0, 0, 0, 0);
    frm_split = 200;
    place("split_too_far", 0, 0, 0, 0);
    // R2 R9: large-packet off gives zero header buffer
    cfg_lpe = 0; cfg_ring_bytes = 4096; frm_split = 54;
    place("split_lpe_off", 0, 0, 0, 0);
    // R1 R9: unknown type code
    cfg_lpe = 1; cfg_buf_type = 3'b010;
    place("bad_type", 0, 0, 0, 0);
    // R8 R9: a drop mid-frame resets the offset
    cfg_buf_type = 3'b101; frm_len = 3000; frm_split = 60;
    place("mid_first", 0, 0, 0, 0);
    cfg_buf_type = 3'b011;
    place("mid_drop", 0, 0, 0, 0);
    cfg_buf_type = 3'b101; frm_len = 120;
    place("after_drop", 0, 0, 0, 0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule